// File: doc/BRIEF.md
# Floating-point status register updater

This block holds the 32-bit floating-point status and control word of a processor core and brings it up to date at the end of every floating-point operation. The arithmetic unit reports, with a one-cycle `opDone` strobe, what the operation saw: overflow, underflow, divide-by-zero, inexact, fraction-rounded and fraction-inexact conditions, a vector of invalid-operation causes, and an optional new result-class and condition code. Within that single clock edge the block applies every per-operation update. It then recomputes the invalid summary and the enabled-exception summary from the updated word.

When the operation carries the record bit, four summary bits are copied into a 4-bit condition field for the condition register. A program-interrupt request is raised whenever the enabled-exception summary is set and either floating-point exception-mode bit from the machine state register is nonzero. Software can load the whole word through a write port. The two derived summaries are recomputed from the loaded value, so they never disagree with the bits they summarise.

Top module: `fpsr_updater`

## Requirements
- R1: On `opDone`, bits 28 (overflow), 27 (underflow) and 26 (divide-by-zero) take the value of their conditions. A true condition also sets bit 31 (exception summary). A false condition clears its own bit and leaves bit 31 unchanged.
- R2: On `opDone`, a true inexact condition sets bit 25 and bit 31. A false one never clears bit 25.
- R3: On `opDone`, bit 18 takes the fraction-rounded condition and bit 17 takes the fraction-inexact condition. Neither has any effect on bit 31.
- R4: On `opDone`, `invCauses` is ORed into bits 24:19 (cause i at bit 19+i). Any nonzero cause also sets bit 31.
- R5: After every update, bit 29 (invalid summary) equals the OR of bits 24:19.
- R6: After every update, bit 30 equals (b29&b11)|(b28&b10)|(b27&b9)|(b26&b8)|(b25&b7). Bits 11..7 are the enables for invalid, overflow, underflow, divide-by-zero and inexact.
- R7: On `opDone` with `recordBit`, `cr1Field` becomes {b31,b30,b29,b28} of the updated word. Otherwise `cr1Field` holds its value.
- R8: `irqReq` equals bit 30 AND (`msrFeMode` != 0).
- R9: On `opDone` with `flagsWrEn`, bits 16:12 are replaced by `resFlags`. With only `ccWrEn`, bits 15:12 are replaced by `condCode` and bit 16 is kept. `flagsWrEn` wins when both are set.
- R10: `swWrEn` loads `swData` into the word, and bits 29 and 30 are then recomputed as in R5 and R6. When `swWrEn` and `opDone` are both set, the software write wins and the operation is dropped.
- R11: Reset clears the word and `cr1Field`. With neither `opDone` nor `swWrEn`, the word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opDone | input | 1 | End-of-operation strobe |
| ovfCond | input | 1 | Overflow condition |
| unfCond | input | 1 | Underflow condition |
| zdivCond | input | 1 | Divide-by-zero condition |
| inexCond | input | 1 | Inexact condition |
| fracRndCond | input | 1 | Fraction-rounded condition |
| fracInexCond | input | 1 | Fraction-inexact condition |
| invCauses | input | 6 | Invalid-operation cause bits |
| flagsWrEn | input | 1 | Replace the whole result-flags field |
| resFlags | input | 5 | New result class and condition code |
| ccWrEn | input | 1 | Replace the condition code only |
| condCode | input | 4 | New condition code |
| recordBit | input | 1 | Copy the summaries into the condition field |
| swWrEn | input | 1 | Software load of the whole word |
| swData | input | 32 | Software load value |
| msrFeMode | input | 2 | Floating-point exception-mode bits |
| fpStatus | output | 32 | Current status and control word |
| cr1Field | output | 4 | Condition field 1 |
| irqReq | output | 1 | Program-interrupt request |

## Verification
The checker watches every cycle for the relations that must always hold: the two derived summaries match their sources, the interrupt request follows the summary and mode bits, and each strobe leaves its expected mark one cycle later (bit copies, stickiness, the exception summary being kept, the precedence of software writes). The bench scenarios cover behaviour that depends on an accumulated history: a sequence of operations that builds, clears and re-sets bits against a reference word. They also cover the derived bits being corrected after a software load, the choice between whole-field and condition-code-only writes, and the interrupt request under each mode setting.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int WORD_W  = 32;
  localparam int INV_W   = 6;
  localparam int FLAG_W  = 5;
  localparam int CC_W    = 4;
  localparam int MODE_W  = 2;

  // bit positions of the status word
  localparam int FX_B    = 31;
  localparam int FEX_B   = 30;
  localparam int VX_B    = 29;
  localparam int OX_B    = 28;
  localparam int UX_B    = 27;
  localparam int ZX_B    = 26;
  localparam int XX_B    = 25;
  localparam int INV_LO  = 19;
  localparam int INV_HI  = INV_LO + INV_W - 1;
  localparam int FR_B    = 18;
  localparam int FI_B    = 17;
  localparam int FLAG_LO = 12;
  localparam int FLAG_HI = FLAG_LO + FLAG_W - 1;
  localparam int CC_LO   = FLAG_LO;
  localparam int CC_HI   = CC_LO + CC_W - 1;
  localparam int VE_B    = 11;
  localparam int OE_B    = 10;
  localparam int UE_B    = 9;
  localparam int ZE_B    = 8;
  localparam int XE_B    = 7;

  typedef struct packed {
    logic loadSw;
    logic applyOp;
    logic writeFlags;
    logic writeCc;
    logic record;
  } strobes_t;

  typedef struct packed {
    logic              ovf;
    logic              unf;
    logic              zdiv;
    logic              inex;
    logic              fr;
    logic              fi;
    logic [INV_W-1:0]  inv;
    logic [FLAG_W-1:0] flags;
    logic [CC_W-1:0]   cc;
  } opInfo_t;
endpackage

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
(
  input  logic              opDone,
  input  logic              swWrEn,
  input  logic              flagsWrEn,
  input  logic              ccWrEn,
  input  logic              recordBit,
  input  logic              fexNow,
  input  logic [MODE_W-1:0] msrFeMode,
  output strobes_t          strobes,
  output logic              irqReq
);
  logic opTakes;

  // a software load pre-empts an operation landing in the same cycle
  assign opTakes = opDone & ~swWrEn;

  always_comb begin
    strobes            = '0;
    strobes.loadSw     = swWrEn;
    strobes.applyOp    = opTakes;
    strobes.writeFlags = opTakes & flagsWrEn;
    strobes.writeCc    = opTakes & ccWrEn & ~flagsWrEn;
    strobes.record     = opTakes & recordBit;
  end

  assign irqReq = fexNow & (|msrFeMode);
endmodule

// File: rtl/fpsr_datapath.sv
module fpsr_datapath
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  opInfo_t           op,
  input  logic [WORD_W-1:0] swData,
  output logic [WORD_W-1:0] statusQ,
  output logic [3:0]        cr1Q
);
  logic [WORD_W-1:0] preWord;
  logic [WORD_W-1:0] nextWord;
  logic              anyRaised;

  assign anyRaised = op.ovf | op.unf | op.zdiv | op.inex | (|op.inv);

  // stage 1: per-operation or software updates
  always_comb begin
    preWord = statusQ;
    if (strobes.loadSw) begin
      preWord = swData;
    end else if (strobes.applyOp) begin
      preWord[OX_B] = op.ovf;
      preWord[UX_B] = op.unf;
      preWord[ZX_B] = op.zdiv;
      preWord[XX_B] = statusQ[XX_B] | op.inex;
      preWord[FR_B] = op.fr;
      preWord[FI_B] = op.fi;
      preWord[INV_HI:INV_LO] = statusQ[INV_HI:INV_LO] | op.inv;
      if (anyRaised) preWord[FX_B] = 1'b1;
      if (strobes.writeFlags) begin
        preWord[FLAG_HI:FLAG_LO] = op.flags;
      end else if (strobes.writeCc) begin
        preWord[CC_HI:CC_LO] = op.cc;
      end
    end
  end

  // stage 2: derived summaries from the updated word
  always_comb begin
    nextWord        = preWord;
    nextWord[VX_B]  = |preWord[INV_HI:INV_LO];
    nextWord[FEX_B] = (nextWord[VX_B] & preWord[VE_B])
                    | (preWord[OX_B] & preWord[OE_B])
                    | (preWord[UX_B] & preWord[UE_B])
                    | (preWord[ZX_B] & preWord[ZE_B])
                    | (preWord[XX_B] & preWord[XE_B]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      cr1Q    <= '0;
    end else begin
      statusQ <= nextWord;
      if (strobes.record)
        cr1Q <= {nextWord[FX_B], nextWord[FEX_B], nextWord[VX_B], nextWord[OX_B]};
    end
  end
endmodule

// File: rtl/fpsr_updater.sv
module fpsr_updater
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opDone,
  input  logic              ovfCond,
  input  logic              unfCond,
  input  logic              zdivCond,
  input  logic              inexCond,
  input  logic              fracRndCond,
  input  logic              fracInexCond,
  input  logic [INV_W-1:0]  invCauses,
  input  logic              flagsWrEn,
  input  logic [FLAG_W-1:0] resFlags,
  input  logic              ccWrEn,
  input  logic [CC_W-1:0]   condCode,
  input  logic              recordBit,
  input  logic              swWrEn,
  input  logic [WORD_W-1:0] swData,
  input  logic [MODE_W-1:0] msrFeMode,
  output logic [WORD_W-1:0] fpStatus,
  output logic [3:0]        cr1Field,
  output logic              irqReq
);
  strobes_t strobes;
  opInfo_t  opInfo;

  assign opInfo = '{ovf: ovfCond, unf: unfCond, zdiv: zdivCond, inex: inexCond,
                    fr: fracRndCond, fi: fracInexCond, inv: invCauses,
                    flags: resFlags, cc: condCode};

  fpsr_ctrl i_ctrl (
    .opDone    (opDone),
    .swWrEn    (swWrEn),
    .flagsWrEn (flagsWrEn),
    .ccWrEn    (ccWrEn),
    .recordBit (recordBit),
    .fexNow    (fpStatus[FEX_B]),
    .msrFeMode (msrFeMode),
    .strobes   (strobes),
    .irqReq    (irqReq)
  );

  fpsr_datapath i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .op      (opInfo),
    .swData  (swData),
    .statusQ (fpStatus),
    .cr1Q    (cr1Field)
  );
endmodule

// File: rtl/fpsr_updater_chk.sv
module fpsr_updater_chk
  import fpsr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              opDone,
  input logic              ovfCond,
  input logic              unfCond,
  input logic              zdivCond,
  input logic              inexCond,
  input logic              fracRndCond,
  input logic              fracInexCond,
  input logic [INV_W-1:0]  invCauses,
  input logic              flagsWrEn,
  input logic [FLAG_W-1:0] resFlags,
  input logic              ccWrEn,
  input logic [CC_W-1:0]   condCode,
  input logic              recordBit,
  input logic              swWrEn,
  input logic [WORD_W-1:0] swData,
  input logic [MODE_W-1:0] msrFeMode,
  input logic [WORD_W-1:0] fpStatus,
  input logic [3:0]        cr1Field,
  input logic              irqReq
);
  logic opOk;
  logic quietOp;
  assign opOk    = opDone & ~swWrEn;
  assign quietOp = opOk & ~ovfCond & ~unfCond & ~zdivCond & ~inexCond & (invCauses == '0);

  p_ovf_sets_fx_r1: assert property (@(posedge clk) disable iff (!rstN)
    opOk && ovfCond |=> fpStatus[OX_B] && fpStatus[FX_B]);

  p_quiet_keeps_fx_r1: assert property (@(posedge clk) disable iff (!rstN)
    quietOp |=> fpStatus[FX_B] == $past(fpStatus[FX_B]) && !fpStatus[OX_B]);

  p_inexact_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    opOk && fpStatus[XX_B] |=> fpStatus[XX_B]);

  p_frac_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    opOk |=> fpStatus[FR_B] == $past(fracRndCond) && fpStatus[FI_B] == $past(fracInexCond));

  p_inv_or_r4: assert property (@(posedge clk) disable iff (!rstN)
    opOk |=> (fpStatus[INV_HI:INV_LO] & $past(invCauses)) == $past(invCauses));

  p_vx_summary_r5: assert property (@(posedge clk) disable iff (!rstN)
    fpStatus[VX_B] == (|fpStatus[INV_HI:INV_LO]));

  p_fex_pairs_r6: assert property (@(posedge clk) disable iff (!rstN)
    fpStatus[FEX_B] == ((fpStatus[VX_B] & fpStatus[VE_B]) | (fpStatus[OX_B] & fpStatus[OE_B])
                      | (fpStatus[UX_B] & fpStatus[UE_B]) | (fpStatus[ZX_B] & fpStatus[ZE_B])
                      | (fpStatus[XX_B] & fpStatus[XE_B])));

  p_cr1_copy_r7: assert property (@(posedge clk) disable iff (!rstN)
    opOk && recordBit |=> cr1Field == {fpStatus[FX_B], fpStatus[FEX_B], fpStatus[VX_B], fpStatus[OX_B]});

  p_cr1_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(opOk && recordBit) |=> $stable(cr1Field));

  p_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (fpStatus[FEX_B] && msrFeMode != '0));

  p_cc_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    opOk && ccWrEn && !flagsWrEn |=>
      fpStatus[CC_HI:CC_LO] == $past(condCode) && fpStatus[FLAG_HI] == $past(fpStatus[FLAG_HI]));

  p_sw_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    swWrEn |=> fpStatus[28:0] == $past(swData[28:0]) && fpStatus[FX_B] == $past(swData[FX_B]));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !opDone && !swWrEn |=> $stable(fpStatus));
endmodule

bind fpsr_updater fpsr_updater_chk i_chk (.*);

// File: tb/test_fpsr_updater.sv
`timescale 1ns/1ps
module test_fpsr_updater;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opDone = 0, ovfCond = 0, unfCond = 0, zdivCond = 0, inexCond = 0;
  logic        fracRndCond = 0, fracInexCond = 0;
  logic [5:0]  invCauses = '0;
  logic        flagsWrEn = 0, ccWrEn = 0, recordBit = 0, swWrEn = 0;
  logic [4:0]  resFlags = '0;
  logic [3:0]  condCode = '0;
  logic [31:0] swData = '0;
  logic [1:0]  msrFeMode = '0;
  logic [31:0] fpStatus;
  logic [3:0]  cr1Field;
  logic        irqReq;

  int checks = 0;
  int errors = 0;
  logic [31:0] expWord = '0;
  logic [3:0]  expCr1 = '0;

  always #2 clk = ~clk;

  fpsr_updater i_fpsr_updater (.*);

  // stimulus word: [23]ovf [22]unf [21]zdiv [20]inex [19]fr [18]fi [17:12]inv
  //                [11]record [10]flagsEn [9:5]flags [4]ccEn [3:0]cc
  localparam int NVEC = 10;
  localparam logic [23:0] VECS [NVEC] = '{
    {6'b100000, 6'h00, 1'b1, 1'b0, 5'h00, 1'b0, 4'h0},
    {6'b000000, 6'h00, 1'b1, 1'b0, 5'h00, 1'b0, 4'h0},
    {6'b000100, 6'h00, 1'b0, 1'b0, 5'h00, 1'b0, 4'h0},
    {6'b000011, 6'h00, 1'b1, 1'b0, 5'h00, 1'b0, 4'h0},
    {6'b000000, 6'h05, 1'b1, 1'b0, 5'h00, 1'b0, 4'h0},
    {6'b011000, 6'h00, 1'b0, 1'b1, 5'h11, 1'b0, 4'h0},
    {6'b000000, 6'h00, 1'b0, 1'b0, 5'h00, 1'b1, 4'h2},
    {6'b000000, 6'h00, 1'b1, 1'b1, 5'h0C, 1'b1, 4'h3},
    {6'b000000, 6'h20, 1'b1, 1'b0, 5'h00, 1'b0, 4'h0},
    {6'b000000, 6'h00, 1'b1, 1'b0, 5'h00, 1'b0, 4'h0}
  };

  function automatic logic [31:0] fixSummaries(input logic [31:0] w);
    logic [31:0] r = w;
    r[29] = |r[24:19];
    r[30] = (r[29] & r[11]) | (r[28] & r[10]) | (r[27] & r[9]) | (r[26] & r[8]) | (r[25] & r[7]);
    return r;
  endfunction

  function automatic logic [31:0] applyModel(input logic [31:0] w, input logic [23:0] v);
    logic [31:0] r = w;
    r[28] = v[23];
    r[27] = v[22];
    r[26] = v[21];
    if (v[20]) r[25] = 1'b1;
    r[18] = v[19];
    r[17] = v[18];
    r[24:19] = r[24:19] | v[17:12];
    if (v[23] || v[22] || v[21] || v[20] || v[17:12] != 0) r[31] = 1'b1;
    if (v[10]) r[16:12] = v[9:5];
    else if (v[4]) r[15:12] = v[3:0];
    return fixSummaries(r);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic driveVec(input logic [23:0] v);
    {ovfCond, unfCond, zdivCond, inexCond, fracRndCond, fracInexCond} = v[23:18];
    invCauses = v[17:12];
    recordBit = v[11];
    flagsWrEn = v[10];
    resFlags  = v[9:5];
    ccWrEn    = v[4];
    condCode  = v[3:0];
  endtask

  task automatic idleInputs();
    opDone = 0; swWrEn = 0;
    driveVec('0);
  endtask

  task automatic checkAll(input string tag);
    check({tag, " word"}, fpStatus, expWord);
    check({tag, " cr1"}, {28'h0, cr1Field}, {28'h0, expCr1});
    check({tag, " irq"}, {31'h0, irqReq}, {31'h0, expWord[30] & (msrFeMode != 0)});
  endtask

  task automatic doOp(input logic [23:0] v, input string tag);
    @(negedge clk);
    driveVec(v);
    opDone = 1;
    expWord = applyModel(expWord, v);
    if (v[11]) expCr1 = {expWord[31], expWord[30], expWord[29], expWord[28]};
    @(negedge clk);
    idleInputs();
    checkAll(tag);
  endtask

  task automatic doSw(input logic [31:0] d, input string tag);
    @(negedge clk);
    swWrEn = 1;
    swData = d;
    expWord = fixSummaries(d);
    @(negedge clk);
    idleInputs();
    checkAll(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    checkAll("R11 reset");
    rstN = 1;
    @(negedge clk);

    // enable all five exceptions, then walk the table
    doSw(32'h0000_0F80, "R10 enables");
    for (int i = 0; i < NVEC; i++) begin
      doOp(VECS[i], $sformatf("R1/R2/R3/R4/R5/R6/R7/R9 vec%0d", i));
    end

    // R10: stale summaries in the loaded value are corrected
    doSw(32'h6000_0000, "R10 summaries recomputed");
    check("R10 vx cleared", {31'h0, fpStatus[29]}, 32'h0);

    // R3: fraction bits do not touch the exception summary
    doOp({6'b000011, 6'h00, 1'b0, 1'b0, 5'h00, 1'b0, 4'h0}, "R3 frac only");
    check("R3 fx untouched", {31'h0, fpStatus[31]}, 32'h0);

    // R1: a cleared overflow leaves the exception summary set
    doOp({6'b100000, 6'h00, 1'b0, 1'b0, 5'h00, 1'b0, 4'h0}, "R1 ovf set");
    doOp(24'h0, "R1 ovf clear");
    check("R1 fx kept", {31'h0, fpStatus[31]}, 32'h1);
    check("R1 ox cleared", {31'h0, fpStatus[28]}, 32'h0);

    // R2: inexact survives a quiet operation
    doOp({6'b000100, 6'h00, 1'b0, 1'b0, 5'h00, 1'b0, 4'h0}, "R2 inexact set");
    doOp(24'h0, "R2 inexact kept");
    check("R2 xx sticky", {31'h0, fpStatus[25]}, 32'h1);

    // R9: condition-code-only write keeps the class bit
    doOp({6'b000000, 6'h00, 1'b0, 1'b1, 5'h1F, 1'b0, 4'h0}, "R9 flags whole");
    doOp({6'b000000, 6'h00, 1'b0, 1'b0, 5'h00, 1'b1, 4'h4}, "R9 cc only");
    check("R9 field", {27'h0, fpStatus[16:12]}, 32'h14);

    // R8: interrupt request under each mode setting
    doSw(32'h0008_0800, "R8 invalid enabled");
    for (int m = 0; m < 4; m++) begin
      msrFeMode = m[1:0];
      #1;
      check($sformatf("R8 mode%0d", m), {31'h0, irqReq}, {31'h0, m != 0});
    end
    msrFeMode = 2'b00;

    // R10: software write wins over a same-cycle operation
    @(negedge clk);
    swWrEn = 1; swData = 32'h0000_0400; opDone = 1;
    driveVec({6'b111100, 6'h3F, 1'b1, 1'b0, 5'h00, 1'b0, 4'h0});
    expWord = fixSummaries(32'h0000_0400);
    @(negedge clk);
    idleInputs();
    checkAll("R10 sw wins");

    // R7: no record bit leaves cr1 alone
    doOp({6'b100000, 6'h00, 1'b0, 1'b0, 5'h00, 1'b0, 4'h0}, "R7 no record");

    // R11: idle cycles hold the word
    repeat (3) @(negedge clk);
    checkAll("R11 idle hold");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule